// File: doc/BRIEF.md
# PHY Control-Register Port Master

This engine runs one read or one write on a slow, serially clocked control-register port of a PHY. Without it, firmware would have to toggle each port line in turn. The host gives a 16-bit register address, a direction bit and, for writes, 16-bit data, and then pulses `start`. The engine then runs the whole handshake on the port. When the access ends it raises `done` for one cycle. It returns the data that was read, or reports through `timeout` that the PHY never acknowledged.

An access has five steps, always in the same order:

1. Idle port clocks. A long run of port-clock pulses is sent with select and both enables low.
2. Select setup. Select rises and is held for one port-clock phase.
3. Launch. The enable that matches the direction is held high for exactly one port-clock pulse.
4. Acknowledge polling. The acknowledge input is sampled a bounded number of times, with one extra port-clock pulse between samples.
5. Done.

Each port-clock phase lasts `PHASE_CYCLES` system clocks, so the port runs well below the system clock. Retries above the level of a single access are left to the host.

Top module: `phycr_master`

## Requirements
- R1: While `rst` is high and after it is released, `port_clk`, `port_sel`, `port_rd_en`, `port_wr_en`, `busy`, `done`, `timeout` and `rdata` are all 0.
- R2: An access begins in the cycle after `start` is accepted with `PRE_PULSES` (100) port-clock pulses. Each pulse is `PHASE_CYCLES` (4) cycles high and then the same number low. Select and both enables stay low during these pulses.
- R3: When the idle pulses end, `port_sel` rises with `port_clk` low for one phase. It then stays high through the cycle in which `done` is high, and falls in the next cycle.
- R4: `port_addr` takes `addr` when `start` is accepted and holds it until the next accepted start. `port_wdata` takes `wdata` only when the access is a write (`wr`=1). A read leaves `port_wdata` unchanged.
- R5: After the select phase, `port_wr_en` (when `wr`=1) or `port_rd_en` (when `wr`=0) is high for exactly one port-clock pulse, which is 2*`PHASE_CYCLES` cycles with the clock high first. Both enables then go low. The two enables are never high together.
- R6: After the launch pulse comes one polling cycle with the port clock low, in which `port_ack` is sampled. If it is high, `done` follows in the next cycle. If it is low, one port-clock pulse is given and then a new polling cycle follows.
- R7: If `port_ack` is low in all `ACK_TRIES` (10) polling cycles, the pulse after the last try is followed by `done` with `timeout`=1. A successful access ends with `timeout`=0. `timeout` clears when a start is accepted and otherwise holds its value.
- R8: On a read, `rdata` takes `port_rdata` from the polling cycle in which the acknowledge is seen. A write, or a read that times out, leaves `rdata` unchanged. Data offered before the acknowledge is never captured.
- R9: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle. A start during an access changes neither the port waveform nor `port_addr`.
- R10: `done` is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run one access |
| wr | input | 1 | Direction: 1 = write, 0 = read |
| addr | input | 16 | PHY register address |
| wdata | input | 16 | Data for a write |
| rdata | output | 16 | Data returned by the last acknowledged read |
| done | output | 1 | One-cycle end-of-access pulse |
| timeout | output | 1 | Last access ended without acknowledge |
| busy | output | 1 | Access in progress |
| port_clk | output | 1 | Port clock |
| port_sel | output | 1 | Port select |
| port_rd_en | output | 1 | Read enable |
| port_wr_en | output | 1 | Write enable |
| port_addr | output | 16 | Register address bus |
| port_wdata | output | 16 | Write data bus |
| port_rdata | input | 16 | Read data bus from the PHY |
| port_ack | input | 1 | Acknowledge from the PHY |

## Verification
The bound checker watches these properties on every cycle:

- the two enables are never high together, and an enable is only high under select;
- no port-clock high phase is longer than `PHASE_CYCLES`;
- `done` is a single-cycle pulse, and a `done` without timeout always follows a high acknowledge;
- the address bus stays stable while busy, and busy cannot drop before `done`.

Other properties need a known stimulus, so only the bench scenarios can show them. These are the exact count of 100 idle pulses, the cycle on which select rises, the number of retry pulses before a timeout, and whether read data is captured only from the acknowledge cycle. The bench compares every port line against a per-cycle expected waveform. It does this with the acknowledge arriving on the first try, on a middle try, on the last try, and never.

// File: rtl/phycr_pkg.sv
package phycr_pkg;

    localparam int unsigned CR_ADDR_W = 16;
    localparam int unsigned CR_DATA_W = 16;

    // Sequencer steps of one access, in the order they occur
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SETUP,
        ST_STROBE,
        ST_POLL,
        ST_RETRY,
        ST_DONE
    } seq_state_t;

    // Kind of timed segment the phase generator produces
    typedef enum logic {
        SEG_PULSE,   // one phase high, one phase low
        SEG_GAP      // one phase low only
    } seg_kind_t;

    // Control lines toward the PHY
    typedef struct packed {
        logic clk;
        logic sel;
        logic rd_en;
        logic wr_en;
    } port_ctl_t;

    // Counter width for a limit, never less than one bit
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit <= 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/phycr_phase_gen.sv
module phycr_phase_gen
    import phycr_pkg::*;
#(
    parameter int unsigned PHASE_CYCLES = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  seg_kind_t kind,
    output logic      pclk,
    output logic      seg_last
);

    localparam int unsigned    CW   = cnt_width(PHASE_CYCLES);
    localparam logic [CW-1:0]  LAST = CW'(PHASE_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          hi;
    logic          act;

    // A new segment may be launched in the final cycle of the current one
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            hi  <= 1'b0;
            act <= 1'b0;
        end else if (go) begin
            act <= 1'b1;
            hi  <= (kind == SEG_PULSE);
            cnt <= '0;
        end else if (act) begin
            if (cnt == LAST) begin
                cnt <= '0;
                if (hi) begin
                    hi <= 1'b0;
                end else begin
                    act <= 1'b0;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign pclk     = hi;
    assign seg_last = act && !hi && (cnt == LAST);

endmodule

// File: rtl/phycr_step_counter.sv
module phycr_step_counter
    import phycr_pkg::*;
#(
    parameter int unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_last
);

    localparam int unsigned   CW    = cnt_width(LIMIT);
    localparam logic [CW-1:0] FINAL = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == FINAL);

endmodule

// File: rtl/phycr_seq.sv
module phycr_seq
    import phycr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       seg_last,
    input  logic       pre_last,
    input  logic       try_last,
    input  logic       ack,
    input  logic       dir_wr,
    output seq_state_t state,
    output logic       go,
    output seg_kind_t  kind,
    output logic       pre_clr,
    output logic       pre_inc,
    output logic       try_clr,
    output logic       try_inc,
    output logic       load,
    output logic       capture,
    output logic       set_tout
);

    seq_state_t nxt;

    always_comb begin
        nxt      = state;
        go       = 1'b0;
        kind     = SEG_PULSE;
        pre_clr  = 1'b0;
        pre_inc  = 1'b0;
        try_clr  = 1'b0;
        try_inc  = 1'b0;
        load     = 1'b0;
        capture  = 1'b0;
        set_tout = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    pre_clr = 1'b1;
                    go      = 1'b1;
                    nxt     = ST_PRE;
                end
            end
            ST_PRE: begin
                if (seg_last) begin
                    pre_inc = 1'b1;
                    go      = 1'b1;
                    if (pre_last) begin
                        kind = SEG_GAP;
                        nxt  = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                if (seg_last) begin
                    go  = 1'b1;
                    nxt = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (seg_last) begin
                    try_clr = 1'b1;
                    nxt     = ST_POLL;
                end
            end
            ST_POLL: begin
                if (ack) begin
                    capture = !dir_wr;
                    nxt     = ST_DONE;
                end else begin
                    go  = 1'b1;
                    nxt = ST_RETRY;
                end
            end
            ST_RETRY: begin
                if (seg_last) begin
                    try_inc = 1'b1;
                    if (try_last) begin
                        set_tout = 1'b1;
                        nxt      = ST_DONE;
                    end else begin
                        nxt = ST_POLL;
                    end
                end
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/phycr_xfer_regs.sv
module phycr_xfer_regs #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] port_rdata,
    input  logic              set_tout,
    output logic              dir_wr,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              tout_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_wr  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            tout_q  <= 1'b0;
        end else begin
            if (load) begin
                dir_wr <= wr;
                addr_q <= addr;
                tout_q <= 1'b0;
                if (wr) begin
                    wdata_q <= wdata;
                end
            end
            if (capture) begin
                rdata_q <= port_rdata;
            end
            if (set_tout) begin
                tout_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/phycr_master.sv
module phycr_master
    import phycr_pkg::*;
#(
    parameter int unsigned ADDR_W       = CR_ADDR_W,
    parameter int unsigned DATA_W       = CR_DATA_W,
    parameter int unsigned PHASE_CYCLES = 4,
    parameter int unsigned PRE_PULSES   = 100,
    parameter int unsigned ACK_TRIES    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              timeout,
    output logic              busy,
    output logic              port_clk,
    output logic              port_sel,
    output logic              port_rd_en,
    output logic              port_wr_en,
    output logic [ADDR_W-1:0] port_addr,
    output logic [DATA_W-1:0] port_wdata,
    input  logic [DATA_W-1:0] port_rdata,
    input  logic              port_ack
);

    seq_state_t state;
    seg_kind_t  kind;
    logic       go, seg_last, pclk;
    logic       pre_clr, pre_inc, pre_last;
    logic       try_clr, try_inc, try_last;
    logic       load, capture, set_tout, dir_wr;
    port_ctl_t  ctl;

    phycr_phase_gen #(.PHASE_CYCLES(PHASE_CYCLES)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .kind     (kind),
        .pclk     (pclk),
        .seg_last (seg_last)
    );

    phycr_step_counter #(.LIMIT(PRE_PULSES)) u_pre_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (pre_clr),
        .inc     (pre_inc),
        .at_last (pre_last)
    );

    phycr_step_counter #(.LIMIT(ACK_TRIES)) u_try_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (try_clr),
        .inc     (try_inc),
        .at_last (try_last)
    );

    phycr_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .seg_last (seg_last),
        .pre_last (pre_last),
        .try_last (try_last),
        .ack      (port_ack),
        .dir_wr   (dir_wr),
        .state    (state),
        .go       (go),
        .kind     (kind),
        .pre_clr  (pre_clr),
        .pre_inc  (pre_inc),
        .try_clr  (try_clr),
        .try_inc  (try_inc),
        .load     (load),
        .capture  (capture),
        .set_tout (set_tout)
    );

    phycr_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .wr         (wr),
        .addr       (addr),
        .wdata      (wdata),
        .capture    (capture),
        .port_rdata (port_rdata),
        .set_tout   (set_tout),
        .dir_wr     (dir_wr),
        .addr_q     (port_addr),
        .wdata_q    (port_wdata),
        .rdata_q    (rdata),
        .tout_q     (timeout)
    );

    // Port control decoded from the sequencer step and the phase generator
    always_comb begin
        ctl.clk   = pclk;
        ctl.sel   = (state == ST_SETUP) || (state == ST_STROBE) ||
                    (state == ST_POLL)  || (state == ST_RETRY)  ||
                    (state == ST_DONE);
        ctl.wr_en = (state == ST_STROBE) && dir_wr;
        ctl.rd_en = (state == ST_STROBE) && !dir_wr;
    end

    assign port_clk   = ctl.clk;
    assign port_sel   = ctl.sel;
    assign port_rd_en = ctl.rd_en;
    assign port_wr_en = ctl.wr_en;
    assign done       = (state == ST_DONE);
    assign busy       = (state != ST_IDLE);

endmodule

// File: rtl/phycr_master_chk.sv
module phycr_master_chk #(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned PHASE_CYCLES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              port_clk,
    input logic              port_sel,
    input logic              port_rd_en,
    input logic              port_wr_en,
    input logic              port_ack,
    input logic [ADDR_W-1:0] port_addr,
    input logic              done,
    input logic              timeout,
    input logic              busy
);

    // Length of the current high run of the port clock, before this cycle
    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst || !port_clk) begin
            hi_run <= '0;
        end else begin
            hi_run <= hi_run + 1'b1;
        end
    end

    a_r5_one_enable: assert property (@(posedge clk) disable iff (rst)
        !(port_rd_en && port_wr_en));

    a_r5_enable_under_sel: assert property (@(posedge clk) disable iff (rst)
        (port_rd_en || port_wr_en) |-> port_sel);

    a_r2_phase_bound: assert property (@(posedge clk) disable iff (rst)
        port_clk |-> (hi_run < 16'(PHASE_CYCLES)));

    a_r3_sel_held: assert property (@(posedge clk) disable iff (rst)
        (port_sel && !done) |=> port_sel);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    a_r9_done_while_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(port_addr));

    a_r6_done_after_ack: assert property (@(posedge clk) disable iff (rst)
        (done && !timeout) |-> $past(port_ack));

    a_r7_timeout_at_done: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> done);

endmodule

bind phycr_master phycr_master_chk #(
    .ADDR_W       (ADDR_W),
    .PHASE_CYCLES (PHASE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .port_clk   (port_clk),
    .port_sel   (port_sel),
    .port_rd_en (port_rd_en),
    .port_wr_en (port_wr_en),
    .port_ack   (port_ack),
    .port_addr  (port_addr),
    .done       (done),
    .timeout    (timeout),
    .busy       (busy)
);

// File: tb/sim_phycr_master.sv
module sim_phycr_master;

    localparam int P     = 4;
    localparam int NPRE  = 100;
    localparam int TRIES = 10;

    typedef struct packed {
        logic pclk;
        logic sel;
        logic ren;
        logic wen;
        logic busy;
        logic done;
        logic tout;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        done, timeout, busy;
    logic        port_clk, port_sel, port_rd_en, port_wr_en;
    logic [15:0] port_addr, port_wdata;
    logic [15:0] port_rdata = '0;
    logic        port_ack = 1'b0;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   finished = 0;
    exp_t q[$];
    logic [15:0] exp_wd = '0;
    logic [15:0] exp_rd = '0;
    logic        exp_to = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    phycr_master u0 (
        .clk(clk), .rst(rst), .start(start), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .done(done), .timeout(timeout), .busy(busy),
        .port_clk(port_clk), .port_sel(port_sel), .port_rd_en(port_rd_en),
        .port_wr_en(port_wr_en), .port_addr(port_addr), .port_wdata(port_wdata),
        .port_rdata(port_rdata), .port_ack(port_ack)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic exp_t mk(input logic pc, input logic s, input logic r,
                                input logic w, input logic d, input logic t);
        exp_t e;
        e.pclk = pc; e.sel = s; e.ren = r; e.wen = w;
        e.busy = 1'b1; e.done = d; e.tout = t;
        return e;
    endfunction

    // Expected per-cycle waveform from the cycle after acceptance to the done cycle
    task automatic build(input bit w, input int ack_try);
        q.delete();
        for (int c = 0; c < 2 * P * NPRE; c++) q.push_back(mk((c % (2 * P)) < P, 0, 0, 0, 0, 0));
        for (int c = 0; c < P; c++) q.push_back(mk(0, 1, 0, 0, 0, 0));
        for (int c = 0; c < 2 * P; c++) q.push_back(mk(c < P, 1, !w, w, 0, 0));
        for (int i = 0; i < TRIES; i++) begin
            q.push_back(mk(0, 1, 0, 0, 0, 0));
            if (i == ack_try) break;
            for (int c = 0; c < 2 * P; c++) q.push_back(mk(c < P, 1, 0, 0, 0, 0));
        end
        q.push_back(mk(0, 1, 0, 0, 1, ack_try < 0));
    endtask

    task automatic check_idle(input string tag);
        chk(tag, "port_clk", port_clk, 0);
        chk(tag, "port_sel", port_sel, 0);
        chk(tag, "port_rd_en", port_rd_en, 0);
        chk(tag, "port_wr_en", port_wr_en, 0);
        chk(tag, "busy", busy, 0);
        chk(tag, "done", done, 0);
    endtask

    task automatic run_xfer(input bit w, input logic [15:0] a, input logic [15:0] d,
                            input logic [15:0] prd, input int ack_try, input bit poke);
        int t_ack;
        t_ack = 2 * P * NPRE + P + 2 * P + 1 + ack_try * (2 * P + 1);
        @(negedge clk);
        start = 1'b1; wr = w; addr = a; wdata = d;
        build(w, ack_try);
        if (w) exp_wd = d;
        if (!w && ack_try >= 0) exp_rd = prd;
        exp_to = (ack_try < 0);
        for (int c = 1; c <= q.size(); c++) begin
            exp_t e;
            @(negedge clk);
            start = 1'b0;
            e = q[c - 1];
            chk("R2", "port_clk", port_clk, e.pclk);
            chk("R3", "port_sel", port_sel, e.sel);
            chk("R5", "port_rd_en", port_rd_en, e.ren);
            chk("R5", "port_wr_en", port_wr_en, e.wen);
            chk("R9", "busy", busy, e.busy);
            chk("R10", "done", done, e.done);
            chk("R4", "port_addr", port_addr, a);
            chk("R4", "port_wdata", port_wdata, exp_wd);
            if (e.done) begin
                chk("R7", "timeout", timeout, e.tout);
                chk("R8", "rdata", rdata, exp_rd);
            end else begin
                chk("R7", "timeout cleared", timeout, 0);
            end
            // Acknowledge from the chosen try on; wrong data before it
            port_ack   = (ack_try >= 0) && (c >= t_ack);
            port_rdata = port_ack ? prd : ~prd;
            if (poke && c == 50) begin
                start = 1'b1; wr = ~w; addr = ~a; wdata = ~d;
            end
        end
        @(negedge clk);
        port_ack = 1'b0;
        check_idle("R3");
        chk("R7", "timeout held", timeout, exp_to);
        chk("R8", "rdata held", rdata, exp_rd);
        chk("R4", "port_addr held", port_addr, a);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1");
        chk("R1", "timeout", timeout, 0);
        chk("R1", "rdata", rdata, 0);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");
        chk("R1", "timeout", timeout, 0);
        chk("R1", "rdata", rdata, 0);

        run_xfer(1, 16'h000F, 16'h1234, 16'hDEAD, 0, 0);   // write, first try
        run_xfer(0, 16'h00A5, 16'h5555, 16'hBEEF, 3, 1);   // read, middle try, start poked
        run_xfer(0, 16'h7001, 16'h0000, 16'hCAFE, -1, 0);  // read timeout, rdata held
        run_xfer(1, 16'hFFFF, 16'hA5A5, 16'h0000, 9, 0);   // write, last try
        run_xfer(0, 16'h8000, 16'hFFFF, 16'h0F0F, 0, 1);   // read after timeout

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule